// File: doc/BRIEF.md
# Sized Load/Store Alignment Unit

This unit connects a 32-bit integer register file to a 32-bit data memory port and carries out byte, halfword, word and doubleword loads and stores. On a load it selects the addressed lanes of the memory word, which is stored in big-endian order. It then widens the value to 32 bits, filling the upper bits either with copies of the value's top bit or with zeros. On a store it copies the low bits of the source register into every lane that the access could use, and it marks the lanes actually written with a byte-enable mask.

A request is accepted in a cycle where `req_valid` is high and the unit is idle. The memory beat follows in the next cycle. During that beat the unit drives the memory port, and either reads the register file (for a store) or writes it (for a load). A doubleword moves through an even/odd register pair in two beats. The even register holds the most significant word, at the base address, and the odd register holds the word at base plus 4. The unit checks address alignment and pair parity. It turns away a bad request with a one-cycle error pulse and makes no access for it.

Top module: `lsu_align`

## Requirements
- R1: Opcode `req_op`: bit 3 selects a store (1) or a load (0). Bits 2:1 give the size: 00 byte, 01 halfword, 10 word, 11 doubleword. Bit 0 selects an unsigned load. A request is accepted only when `req_valid` is high and `busy` is low. Requests presented while `busy` is high are ignored. `busy` is high during every memory beat.
- R2: A signed byte load returns the byte at address offset `a[1:0]`, where offset 0 is memory bits 31:24 and offset 3 is bits 7:0. Bit 7 of that byte is copied into result bits 31:8.
- R3: Unsigned byte and halfword loads force every result bit above the loaded value to zero.
- R4: A signed halfword load returns memory bits 31:16 for offset 0 or bits 15:0 for offset 2. Its bit 15 is copied into result bits 31:16.
- R5: A word load writes the whole memory word to the named register.
- R6: A byte store drives the source byte into all four lanes of `mem_wdata`, with `mem_be` = 1000, 0100, 0010 or 0001 for offsets 0 to 3. A halfword store drives the low 16 bits into both halves, with `mem_be` = 1100 for offset 0 or 0011 for offset 2. A word store drives the full register with `mem_be` = 1111. `mem_be` bit 3 covers data bits 31:24.
- R7: Opcode bit 0 has no effect on stores or on word and doubleword loads.
- R8: A halfword at an odd address, or a word or doubleword whose address is not a multiple of 4, raises `err` for one cycle, in the cycle after acceptance. Such a request makes no memory access and no register write.
- R9: A doubleword naming an odd register raises `err` in the same way, with no access.
- R10: A doubleword load makes two beats in consecutive cycles. The word at the base address goes to the named even register, then the word at base+4 goes to the next odd register. `busy` stays high through both beats.
- R11: A doubleword store writes the even register at the base address and then the odd register at base+4, each with `mem_be` = 1111.
- R12: `mem_addr` is always word aligned: the request address with bits 1:0 cleared, plus 4 on the second doubleword beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code (R1) |
| req_addr | input | ADDR_W | Byte address |
| req_reg | input | REG_W | Destination or source register (the even register for a doubleword) |
| busy | output | 1 | A memory beat is in progress |
| err | output | 1 | One-cycle pulse for a rejected request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle of the access |
| rf_raddr | output | REG_W | Register file read address |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write address |
| rf_wdata | output | 32 | Register file write data |

## Verification
The bench covers all four byte offsets and both halfword offsets, on memory words whose selected lanes have the top bit set and clear. A lane-order mistake would return a neighbouring byte, and a missing or extra sign fill would corrupt the upper bits. Misaligned addresses and odd pair registers check that a rejected request makes no memory or register access at all. The doubleword tests check the even-then-odd order and the base+4 address, including a base address whose second word wraps within the test memory. A request held on `req_valid` while the unit is busy must not disturb the sequence or raise an error.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_reg,
  output logic              busy,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [31:0]       rf_rdata,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [31:0]       rf_wdata
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_D = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT0, ST_BEAT1} st_t;
  st_t st;

  logic              l_store, l_uns, err_q;
  logic [1:0]        l_size;
  logic [ADDR_W-1:0] l_addr;
  logic [REG_W-1:0]  l_reg;

  wire [1:0] sz      = req_op[2:1];
  wire       accept  = req_valid && (st == ST_IDLE);
  wire       misal   = (sz == SZ_H && req_addr[0]) || (sz[1] && req_addr[1:0] != 2'b00);
  wire       oddpair = (sz == SZ_D) && req_reg[0];
  wire       bad     = misal || oddpair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      err_q   <= 1'b0;
      l_store <= 1'b0;
      l_uns   <= 1'b0;
      l_size  <= 2'd0;
      l_addr  <= '0;
      l_reg   <= '0;
    end else begin
      err_q <= accept && bad;
      case (st)
        ST_IDLE: if (accept && !bad) begin
          l_store <= req_op[3];
          l_uns   <= req_op[0];
          l_size  <= sz;
          l_addr  <= req_addr;
          l_reg   <= req_reg;
          st      <= ST_BEAT0;
        end
        ST_BEAT0: st <= (l_size == SZ_D) ? ST_BEAT1 : ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  wire             first  = (st == ST_BEAT0);
  wire             second = (st == ST_BEAT1);
  wire             beat   = first || second;
  wire [1:0]       off    = l_addr[1:0];
  wire [REG_W-1:0] cur_reg = second ? {l_reg[REG_W-1:1], 1'b1} : l_reg;

  logic [7:0]  lane_b;
  logic [15:0] lane_h;
  logic [31:0] ld_val, st_val;
  logic [3:0]  st_be;

  always_comb begin
    case (off)
      2'd0:    lane_b = mem_rdata[31:24];
      2'd1:    lane_b = mem_rdata[23:16];
      2'd2:    lane_b = mem_rdata[15:8];
      default: lane_b = mem_rdata[7:0];
    endcase
    lane_h = off[1] ? mem_rdata[15:0] : mem_rdata[31:16];
    case (l_size)
      SZ_B:    ld_val = {{24{~l_uns & lane_b[7]}}, lane_b};
      SZ_H:    ld_val = {{16{~l_uns & lane_h[15]}}, lane_h};
      default: ld_val = mem_rdata;
    endcase
  end

  always_comb begin
    case (l_size)
      SZ_B: begin
        st_val = {4{rf_rdata[7:0]}};
        st_be  = 4'b1000 >> off;
      end
      SZ_H: begin
        st_val = {2{rf_rdata[15:0]}};
        st_be  = off[1] ? 4'b0011 : 4'b1100;
      end
      default: begin
        st_val = rf_rdata;
        st_be  = 4'b1111;
      end
    endcase
  end

  assign busy      = beat;
  assign err       = err_q;
  assign mem_req   = beat;
  assign mem_we    = beat && l_store;
  assign mem_addr  = {l_addr[ADDR_W-1:2], 2'b00} + (second ? ADDR_W'(4) : ADDR_W'(0));
  assign mem_be    = mem_we ? st_be : 4'b0000;
  assign mem_wdata = st_val;
  assign rf_raddr  = cur_reg;
  assign rf_we     = beat && !l_store;
  assign rf_waddr  = cur_reg;
  assign rf_wdata  = ld_val;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              rf_we,
  input logic [31:0]       rf_wdata,
  input logic              first,
  input logic              second,
  input logic [1:0]        l_size,
  input logic              l_uns
);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_req && !rf_we && !busy));

  a_r6_store_be: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  a_r12_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r10_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (first && l_size == 2'd3) |=> (second && mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4)));

  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && l_uns && l_size == 2'd0) |-> (rf_wdata[31:8] == 24'd0));

  a_r1_busy_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r7_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rf_we);
endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .rf_we(rf_we),
  .rf_wdata(rf_wdata), .first(first), .second(second), .l_size(l_size),
  .l_uns(l_uns)
);

// File: tb/lsu_align_test.sv
module lsu_align_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd0;
  logic [31:0] req_addr = 32'd0;
  logic [4:0]  req_reg = 5'd0;
  logic        busy, err, mem_req, mem_we, rf_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  mem_be;
  logic [4:0]  rf_raddr, rf_waddr;

  logic [31:0] memw [16];
  logic [31:0] regs [32];

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int          q_kind[$];
  logic [31:0] q_a[$], q_b[$], q_c[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = memw[mem_addr[5:2]];
  assign rf_rdata  = regs[rf_raddr];

  lsu_align uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg), .busy(busy), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  task automatic push(input int k, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input string tag);
    q_kind.push_back(k); q_a.push_back(a); q_b.push_back(b);
    q_c.push_back(c); q_tag.push_back(tag);
  endtask

  function automatic logic [31:0] load_val(input logic [3:0] op, input logic [31:0] w,
                                           input logic [1:0] off);
    logic [7:0] b;
    logic [15:0] h;
    b = 8'(w >> (8 * (3 - int'(off))));
    h = off[1] ? w[15:0] : w[31:16];
    case (op[2:1])
      2'd0: return op[0] ? {24'd0, b} : {{24{b[7]}}, b};
      2'd1: return op[0] ? {16'd0, h} : {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  task automatic push_expect(input logic [3:0] op, input logic [31:0] addr,
                             input logic [4:0] rg, input string tag);
    logic [1:0] sz;
    logic [31:0] wa, w;
    logic [3:0] be;
    logic [1:0] off;
    bit bad;
    sz = op[2:1];
    off = addr[1:0];
    wa = {addr[31:2], 2'b00};
    bad = (sz == 2'd1 && addr[0]) || (sz[1] && off != 2'b00) || (sz == 2'd3 && rg[0]);
    if (bad) begin
      push(2, 0, 0, 0, tag);
    end else if (!op[3]) begin
      push(1, {27'd0, rg}, wa, load_val(op, memw[wa[5:2]], off), tag);
      if (sz == 2'd3)
        push(1, {27'd0, rg | 5'd1}, wa + 4, memw[(wa + 4) >> 2 & 32'hF], tag);
    end else begin
      case (sz)
        2'd0: begin
          case (off)
            2'd0: be = 4'b1000;
            2'd1: be = 4'b0100;
            2'd2: be = 4'b0010;
            default: be = 4'b0001;
          endcase
          w = {4{regs[rg][7:0]}};
        end
        2'd1: begin
          be = (off == 2'd0) ? 4'b1100 : 4'b0011;
          w = {2{regs[rg][15:0]}};
        end
        default: begin
          be = 4'b1111;
          w = regs[rg];
        end
      endcase
      push(0, wa, {28'd0, be}, w, tag);
      if (sz == 2'd3)
        push(0, wa + 4, 32'h0000000F, regs[rg | 5'd1], tag);
    end
  endtask

  task automatic expect_true(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] addr,
                       input logic [4:0] rg, input string tag);
    bit bad;
    bad = (op[2:1] == 2'd1 && addr[0]) || (op[2] && addr[1:0] != 2'b00) ||
          (op[2:1] == 2'd3 && rg[0]);
    @(negedge clk);
    while (busy) @(negedge clk);
    push_expect(op, addr, rg, tag);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_reg = rg;
    @(negedge clk);
    req_valid = 1'b0;
    expect_true(busy == !bad, {tag, " R1 busy in beat"}, int'(busy), int'(!bad));
  endtask

  task automatic check_item(input int k, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] c);
    int ek;
    logic [31:0] ea, eb, ec;
    string t;
    vectors++;
    if (q_kind.size() == 0) begin
      fails++;
      $display("FAIL unexpected activity: kind %0d a=%h b=%h c=%h expected none", k, a, b, c);
      return;
    end
    ek = q_kind.pop_front(); ea = q_a.pop_front(); eb = q_b.pop_front();
    ec = q_c.pop_front(); t = q_tag.pop_front();
    if (ek != k || ea != a || eb != b || ec != c) begin
      fails++;
      $display("FAIL %s: actual kind %0d a=%h b=%h c=%h expected kind %0d a=%h b=%h c=%h",
               t, k, a, b, c, ek, ea, eb, ec);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err) check_item(2, 0, 0, 0);
      if (mem_req && mem_we) check_item(0, mem_addr, {28'd0, mem_be}, mem_wdata);
      if (rf_we) check_item(1, {27'd0, rf_waddr}, mem_addr, rf_wdata);
      if (mem_req && !mem_we && !rf_we) check_item(3, mem_addr, 0, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    memw[0] = 32'hF07F_8001;
    memw[1] = 32'h7F80_01FF;
    memw[2] = 32'h1234_5678;
    memw[3] = 32'hCAFE_BABE;
    for (int i = 4; i < 16; i++) memw[i] = (i * 32'h1111_1111) ^ 32'h0080_8000;
    for (int i = 0; i < 32; i++) regs[i] = 32'hA500_0000 | (i * 32'h0001_0203);
    regs[4] = 32'hDEAD_BEEF;
    regs[5] = 32'h0123_4567;

    repeat (3) @(negedge clk);
    expect_true(!busy && !err && !mem_req && !rf_we, "R1 reset idle",
                int'({busy, err, mem_req, rf_we}), 0);
    rst_n = 1'b1;

    for (int o = 0; o < 4; o++) issue(4'b0000, 32'(o), 5'd7, "R2 signed byte");
    for (int o = 0; o < 4; o++) issue(4'b0000, 32'(4 + o), 5'd8, "R2 signed byte w1");
    issue(4'b0001, 32'd0, 5'd9, "R3 unsigned byte off0");
    issue(4'b0001, 32'd2, 5'd9, "R3 unsigned byte off2");
    issue(4'b0011, 32'd0, 5'd10, "R3 unsigned half off0");
    issue(4'b0011, 32'd6, 5'd10, "R3 unsigned half off2");
    issue(4'b0010, 32'd0, 5'd11, "R4 signed half off0");
    issue(4'b0010, 32'd2, 5'd11, "R4 signed half off2");
    issue(4'b0010, 32'd4, 5'd11, "R4 signed half w1 off0");
    issue(4'b0010, 32'd14, 5'd11, "R4 signed half w3 off2");
    issue(4'b0100, 32'd8, 5'd12, "R5 word load");
    issue(4'b0101, 32'd12, 5'd12, "R7 word load op0 set");
    for (int o = 0; o < 4; o++) issue(4'b1000, 32'(16 + o), 5'd4, "R6 byte store");
    issue(4'b1010, 32'd20, 5'd5, "R6 half store off0");
    issue(4'b1010, 32'd22, 5'd5, "R6 half store off2");
    issue(4'b1100, 32'd24, 5'd4, "R6 word store");
    issue(4'b1001, 32'd17, 5'd4, "R7 byte store op0 set");
    issue(4'b1011, 32'd22, 5'd4, "R7 half store op0 set");
    issue(4'b1101, 32'd28, 5'd5, "R7 word store op0 set");
    issue(4'b0111, 32'd8, 5'd2, "R7 dbl load op0 set");
    issue(4'b0010, 32'd1, 5'd13, "R8 half odd addr");
    issue(4'b1010, 32'd3, 5'd13, "R8 half store odd addr");
    issue(4'b0100, 32'd2, 5'd13, "R8 word misaligned");
    issue(4'b1100, 32'd5, 5'd13, "R8 word store misaligned");
    issue(4'b0110, 32'd18, 5'd14, "R8 dbl misaligned");
    issue(4'b0001, 32'd3, 5'd15, "R8 byte any offset ok");
    issue(4'b0110, 32'd8, 5'd5, "R9 dbl load odd reg");
    issue(4'b1110, 32'd8, 5'd3, "R9 dbl store odd reg");
    issue(4'b0110, 32'd8, 5'd6, "R10 dbl load");
    issue(4'b0110, 32'h3C, 5'd20, "R10 dbl load wrap");
    issue(4'b1110, 32'd16, 5'd4, "R11 dbl store");
    issue(4'b1110, 32'd40, 5'd30, "R11 dbl store high pair");

    // R1: a bad request held during a doubleword sequence is ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    push_expect(4'b0110, 32'd0, 5'd16, "R1 dbl with held request");
    req_valid = 1'b1; req_op = 4'b0110; req_addr = 32'd0; req_reg = 5'd16;
    @(negedge clk);
    req_op = 4'b0110; req_addr = 32'd1; req_reg = 5'd17;
    expect_true(busy, "R1 busy beat0", int'(busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_true(busy, "R10 busy beat1", int'(busy), 1);
    @(negedge clk);
    expect_true(!busy && !err, "R1 held request ignored", int'({busy, err}), 0);

    repeat (3) @(negedge clk);
    done = 1;
    vectors++;
    if (q_kind.size() != 0) begin
      fails++;
      $display("FAIL R1 pending expectations: actual %0d outstanding expected 0", q_kind.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule